// File: doc/BRIEF.md
# Peripheral ID Tree Lookup

This block turns a 12-bit peripheral identifier into an 8-bit channel index by walking a binary decision tree kept in a local register array. Each tree node names one identifier bit to test. For each value of that bit, the node either jumps to another node or ends the walk with an 8-bit answer. A walk starts at node 0 and visits one node per clock. If the walk has not ended after a fixed number of visits, the lookup reports not-found.

The identifier is made from a 4-bit slave number in the upper nibble and an 8-bit peripheral number in the lower byte. A caller raises `start` for one cycle with both numbers. While the walk runs, `busy` is high. The answer comes back with a one-cycle `done` pulse, together with `result` and `not_found`. The tree is loaded through a simple write port, one node per write, before any lookup that depends on it.

Top module: `pid_tree_lookup`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `not_found` and `result` are all zero.
- R2: When the tested identifier bit is 1, node bit 8 is the branch flag and bits 7:0 are its 8-bit argument. A flag of 1 jumps to the node indexed by the argument. A flag of 0 ends the walk with the argument as `result`.
- R3: When the tested identifier bit is 0, node bit 17 is the branch flag and bits 16:9 are its 8-bit argument, with the same meaning as in R2.
- R4: Node bits 21:18 give the number of the identifier bit to test. Values 12 to 15 always test as 0.
- R5: The identifier is `{req_slave, req_periph}`: slave bits form identifier bits 11:8, and peripheral bits form identifier bits 7:0.
- R6: Every walk begins at node 0 and evaluates one node per cycle. If the walk ends at its k-th node, `done` is high for exactly one cycle, k cycles after the cycle in which `start` was sampled.
- R7: If 16 nodes have been evaluated and none ended the walk, `done` pulses with `not_found`=1 and `result`=0, 16 cycles after start.
- R8: A `start` that arrives while `busy` is high is ignored. It neither changes the answer or timing of the current walk nor causes a later walk.
- R9: `busy` is high from the cycle after an accepted start up to and including the cycle in which the last node is evaluated. It is low in the `done` cycle.
- R10: A node write takes effect at the clock edge. A node evaluated in the same cycle as a write to it uses the old contents, and the next walk uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Node write strobe |
| cfg_addr | input | 8 | Node index to write |
| cfg_wdata | input | 22 | Node contents (bit layout as in R2 to R4) |
| start | input | 1 | Lookup request pulse |
| req_slave | input | 4 | Slave number, identifier bits 11:8 |
| req_periph | input | 8 | Peripheral number, identifier bits 7:0 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Channel index, valid with done |
| not_found | output | 1 | Depth limit reached, valid with done |

## Verification
Two things can happen in the same cycle: a node write and the sequencer's evaluation of that same node, and a new start and a walk in progress. The bench writes a different terminal value into node 1 in exactly the cycle that node 1 is evaluated. It then expects the old value from the current walk and the new value from the following walk. A second start is pulsed in the middle of a walk that would otherwise run to the depth limit, with an identifier that would end at node 0. The bench judges this by the original walk still ending with not-found after 16 cycles, and no extra `done` appearing afterward.

// File: rtl/pidl_pkg.sv
`timescale 1ns/1ps
package pidl_pkg;
    localparam int SLV_W    = 4;
    localparam int PER_W    = 8;
    localparam int PID_W    = SLV_W + PER_W;
    localparam int IDX_W    = 8;
    localparam int SEL_W    = 4;
    localparam int SEL_SPAN = 1 << SEL_W;
    localparam int NODE_W   = SEL_W + 2 * (IDX_W + 1);

    // one tree node: bit selector, then the 0-branch, then the 1-branch
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             cont0;
        logic [IDX_W-1:0] arg0;
        logic             cont1;
        logic [IDX_W-1:0] arg1;
    } node_t;

    typedef struct packed {
        logic             cont;
        logic [IDX_W-1:0] arg;
    } step_t;

    typedef enum logic {ST_IDLE, ST_WALK} walk_st_e;

    // identifier bit pick; selectors beyond the identifier width read as 0
    function automatic logic pick_bit(input logic [PID_W-1:0] id,
                                      input logic [SEL_W-1:0] sel);
        logic [SEL_SPAN-1:0] ext;
        ext = '0;
        ext[PID_W-1:0] = id;
        return ext[sel];
    endfunction
endpackage

// File: rtl/pidl_node_table.sv
`timescale 1ns/1ps
module pidl_node_table
    import pidl_pkg::*;
#(
    parameter int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  node_t            wr_node,
    input  logic [IDX_W-1:0] rd_idx,
    output node_t            rd_node
);
    node_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_node;
        end
    end

    // read is combinational: a write in this cycle is seen only next cycle
    assign rd_node = mem[rd_idx];
endmodule

// File: rtl/pidl_branch.sv
`timescale 1ns/1ps
module pidl_branch
    import pidl_pkg::*;
(
    input  node_t            node,
    input  logic [PID_W-1:0] id,
    output step_t            step
);
    logic bit_v;

    always_comb begin
        bit_v = pick_bit(id, node.sel);
        if (bit_v) begin
            step.cont = node.cont1;
            step.arg  = node.arg1;
        end else begin
            step.cont = node.cont0;
            step.arg  = node.arg0;
        end
    end
endmodule

// File: rtl/pidl_walk_seq.sv
`timescale 1ns/1ps
module pidl_walk_seq
    import pidl_pkg::*;
#(
    parameter int MAX_VISIT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PID_W-1:0] start_id,
    input  step_t            step,
    output logic [IDX_W-1:0] node_idx,
    output logic [PID_W-1:0] cur_id,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] result,
    output logic             not_found
);
    localparam int CNT_W = (MAX_VISIT > 1) ? $clog2(MAX_VISIT) : 1;
    localparam logic [CNT_W-1:0] LAST_VISIT = CNT_W'(MAX_VISIT - 1);

    walk_st_e         st_q;
    logic [IDX_W-1:0] node_q;
    logic [PID_W-1:0] id_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             nf_q;
    logic [IDX_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            node_q <= '0;
            id_q   <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            nf_q   <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        id_q   <= start_id;
                        node_q <= '0;
                        cnt_q  <= '0;
                        st_q   <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (!step.cont) begin
                        done_q <= 1'b1;
                        res_q  <= step.arg;
                        nf_q   <= 1'b0;
                        st_q   <= ST_IDLE;
                    end else if (cnt_q == LAST_VISIT) begin
                        done_q <= 1'b1;
                        res_q  <= '0;
                        nf_q   <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        node_q <= step.arg;
                        cnt_q  <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign node_idx  = node_q;
    assign cur_id    = id_q;
    assign busy      = (st_q == ST_WALK);
    assign done      = done_q;
    assign result    = res_q;
    assign not_found = nf_q;
endmodule

// File: rtl/pid_tree_lookup.sv
`timescale 1ns/1ps
module pid_tree_lookup
    import pidl_pkg::*;
#(
    parameter int MAX_VISIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [NODE_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic [SLV_W-1:0]  req_slave,
    input  logic [PER_W-1:0]  req_periph,
    output logic              busy,
    output logic              done,
    output logic [IDX_W-1:0]  result,
    output logic              not_found
);
    node_t            rd_node;
    step_t            step;
    logic [IDX_W-1:0] node_idx;
    logic [PID_W-1:0] cur_id;

    pidl_node_table #(.ENTRIES(1 << IDX_W)) u_table (
        .clk     (clk),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_addr),
        .wr_node (node_t'(cfg_wdata)),
        .rd_idx  (node_idx),
        .rd_node (rd_node)
    );

    pidl_branch u_branch (
        .node (rd_node),
        .id   (cur_id),
        .step (step)
    );

    pidl_walk_seq #(.MAX_VISIT(MAX_VISIT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_id  ({req_slave, req_periph}),
        .step      (step),
        .node_idx  (node_idx),
        .cur_id    (cur_id),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .not_found (not_found)
    );
endmodule

// File: rtl/pidl_checker.sv
`timescale 1ns/1ps
module pidl_checker #(
    parameter int MAX_VISIT = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [7:0] result,
    input logic       not_found
);
    localparam int RUN_W = $clog2(MAX_VISIT + 1) + 1;
    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6: done only follows a cycle of walking
    p_done_after_walk_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));
    // R9: busy is low while done is shown
    p_busy_low_on_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R9: an idle start always begins a walk
    p_start_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> busy);
    // R8: a walk only begins from a start sampled while idle
    p_walk_needs_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    // R7: not-found carries a zero result
    p_nf_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (done && not_found) |-> (result == 8'h00));
    // R7: no walk lasts more than the depth limit
    p_depth_limit_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < RUN_W'(MAX_VISIT)));
endmodule

bind pid_tree_lookup pidl_checker #(.MAX_VISIT(MAX_VISIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .not_found (not_found)
);

// File: tb/tb_pid_tree_lookup.sv
`timescale 1ns/1ps
module tb_pid_tree_lookup;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [21:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic [3:0]  req_slave = '0;
    logic [7:0]  req_periph = '0;
    logic        busy, done, not_found;
    logic [7:0]  result;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [21:0] ref_tbl [256];

    always #5 clk = ~clk;

    pid_tree_lookup dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .req_slave(req_slave),
        .req_periph(req_periph), .busy(busy), .done(done),
        .result(result), .not_found(not_found)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [21:0] mk(input int sel, input int c0, input int a0,
                                       input int c1, input int a1);
        return {sel[3:0], c0[0], a0[7:0], c1[0], a1[7:0]};
    endfunction

    task automatic load(input int a, input logic [21:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[7:0]; cfg_wdata = w;
        ref_tbl[a] = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // expected answer from the requirement text (bit layout of R2..R4, limit of R7)
    task automatic model(input logic [11:0] id, output logic [7:0] r,
                         output logic nf, output int v);
        int node = 0;
        r = 8'h00; nf = 1'b1; v = 16;
        for (int k = 0; k < 16; k++) begin
            logic [21:0] e = ref_tbl[node];
            int sel = int'(e[21:18]);
            logic b = (sel < 12) ? id[sel] : 1'b0;
            logic go = b ? e[8] : e[17];
            logic [7:0] arg = b ? e[7:0] : e[16:9];
            if (!go) begin
                r = arg; nf = 1'b0; v = k + 1;
                return;
            end
            node = int'(arg);
        end
    endtask

    task automatic lookup(input logic [3:0] sl, input logic [7:0] pe, input bit poke,
                          input logic [11:0] pid2, output logic [7:0] r,
                          output logic nf, output int v, output bit busy_ok);
        int c;
        busy_ok = 1;
        @(negedge clk);
        req_slave = sl; req_periph = pe; start = 1'b1;
        @(negedge clk);
        start = 1'b0; c = 1;
        while (!done && c < 40) begin
            if (!busy) busy_ok = 0;
            if (poke && c == 3) begin
                start = 1'b1; {req_slave, req_periph} = pid2;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            c++;
        end
        start = 1'b0;
        if (busy) busy_ok = 0;
        r = result; nf = not_found; v = c - 1;
    endtask

    initial begin
        #1_900_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, er;
        logic nf, enf;
        int v, ev;
        bit bok;

        repeat (4) @(negedge clk);
        chk(busy == 0 && done == 0 && not_found == 0 && result == 0,
            "R1 outputs in reset", {busy, done, not_found, result}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && not_found == 0 && result == 0,
            "R1 outputs after reset", {busy, done, not_found, result}, 0);

        // sweep: arithmetic table with mixed branches, loops and high selectors
        for (int i = 0; i < 256; i++)
            load(i, mk((i * 5 + 1) % 16, (i % 3) != 0, (i * 37 + 11) & 255,
                       (i % 4) != 1, (i * 13 + 7) & 255));
        for (int id = 0; id < 4096; id++) begin
            logic [11:0] pid = id[11:0];
            model(pid, er, enf, ev);
            lookup(pid[11:8], pid[7:0], 0, 12'h000, r, nf, v, bok);
            chk(nf == enf, "R7 sweep not_found", nf, enf);
            chk(r == er, "R2 R3 sweep result", r, er);
            chk(v == ev, "R6 sweep latency", v, ev);
            chk(bok, "R9 sweep busy window", bok, 1);
        end

        // R4: selectors past bit 11 test as 0
        load(0, mk(13, 0, 8'hAA, 0, 8'h55));
        lookup(4'hF, 8'hFF, 0, 12'h000, r, nf, v, bok);
        chk(r == 8'hAA && nf == 0 && v == 1, "R4 selector 13 reads 0", r, 8'hAA);
        load(0, mk(11, 0, 8'hAA, 0, 8'h55));
        lookup(4'h8, 8'h00, 0, 12'h000, r, nf, v, bok);
        chk(r == 8'h55, "R4 selector 11 tests slave msb", r, 8'h55);

        // R5: identifier composition
        load(0, mk(8, 0, 8'h10, 0, 8'h20));
        lookup(4'h1, 8'h00, 0, 12'h000, r, nf, v, bok);
        chk(r == 8'h20, "R5 slave bit0 is id bit 8", r, 8'h20);
        lookup(4'h0, 8'hFF, 0, 12'h000, r, nf, v, bok);
        chk(r == 8'h10, "R5 periph does not reach bit 8", r, 8'h10);
        load(0, mk(7, 0, 8'h10, 0, 8'h20));
        lookup(4'hF, 8'h7F, 0, 12'h000, r, nf, v, bok);
        chk(r == 8'h10, "R5 periph bit7 clear", r, 8'h10);
        lookup(4'h0, 8'h80, 0, 12'h000, r, nf, v, bok);
        chk(r == 8'h20, "R5 periph bit7 set", r, 8'h20);

        // R7 and R8: id bit0=1 loops on node 1; id bit0=0 would end at node 0
        load(0, mk(0, 0, 8'h33, 1, 1));
        load(1, mk(0, 1, 1, 1, 1));
        lookup(4'h0, 8'h01, 0, 12'h000, r, nf, v, bok);
        chk(nf == 1 && r == 0, "R7 depth limit not_found", {nf, r}, 9'h100);
        chk(v == 16, "R7 depth limit latency", v, 16);
        lookup(4'h0, 8'h01, 1, 12'h000, r, nf, v, bok);
        chk(nf == 1 && v == 16, "R8 busy start ignored", v, 16);
        begin
            bit extra = 0;
            repeat (6) begin
                @(negedge clk);
                if (done || busy) extra = 1;
            end
            chk(!extra, "R8 no deferred walk", extra, 0);
        end
        lookup(4'h0, 8'h00, 0, 12'h000, r, nf, v, bok);
        chk(r == 8'h33 && nf == 0 && v == 1, "R6 single node walk", r, 8'h33);

        // R10: write node 1 in the cycle node 1 is evaluated
        load(0, mk(0, 1, 1, 1, 1));
        load(1, mk(0, 0, 8'h11, 0, 8'h11));
        @(negedge clk);
        req_slave = 4'h0; req_periph = 8'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1 && done == 0, "R9 busy after start", busy, 1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'd1; cfg_wdata = mk(0, 0, 8'h22, 0, 8'h22);
        ref_tbl[1] = cfg_wdata;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(done == 1 && result == 8'h11, "R10 walk sees old node", result, 8'h11);
        chk(busy == 0, "R9 busy low with done", busy, 0);
        lookup(4'h0, 8'h00, 0, 12'h000, r, nf, v, bok);
        chk(r == 8'h22 && v == 2, "R10 next walk sees new node", r, 8'h22);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule